// File: doc/BRIEF.md
# Two's-Complement Posit Word Decoder

This block is a purely combinational unpacker for posit numbers. The word width N and the exponent width ES are parameters. It splits one word into a record that the later arithmetic stages share: a NaR flag, a zero flag, a sign, a signed combined scale, the raw fraction bits, a guard/round/sticky triple, and a ready-made two's-complement mantissa.

Negative words are not negated before they are decoded. The regime is found by folding the word with itself shifted by one bit, so that a single leading-zero counter measures both runs of ones and runs of zeros. The exponent and fraction are then aligned with one left shift by the counted length.

For a negative word whose fraction is all zero, the scale comes out one lower than the true exponent. The mantissa in that case is -2.0 instead of -1.0, and the two effects cancel exactly. Every consumer therefore sees the value mantissa × 2^(scale − FW) with the mantissa in [-2,-1) or [1,2).

Top module: `posit_twos_decoder`

## Requirements
- R1: A word with every bit zero raises only the zero flag, and the zero flag is never high together with the NaR flag.
- R2: A word with only the MSB set (100…0) raises only the NaR flag. No other word raises either flag.
- R3: For every word that is neither zero nor NaR, the sign output equals the word's MSB.
- R4: For every normal word, mant_o × 2^(scale_o − FW) equals the posit value exactly. Here mant_o is read as a signed integer and FW = N−ES−3.
- R5: For a normal word, the top two mantissa bits are 01 when the word is positive and 10 when it is negative. This places the mantissa in [1,2) or [-2,-1).
- R6: The guard/round/sticky output is always 000.
- R7: The scale is signed and L(N−2)+ES+1 bits wide, with L(n)=ceil(log2(n+1)). Its upper bits are the regime value and its low ES bits are the exponent. For a positive word it equals regime·2^ES + exponent, and it always lies within [−(N−1)·2^ES, (N−1)·2^ES − 1].
- R8: A negative normal word whose fraction is zero gives mantissa exactly −2.0 (10 followed by zeros) and a scale one below its true exponent.
- R9: A regime run that fills all bits below the sign is decoded correctly. This covers maxpos, minpos and their negatives. When the run ends early, the bit after the run differs from the run.
- R10: With ES = 0 the scale is the regime value alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | N | Posit word to decode |
| is_nar_o | output | 1 | Word is NaR |
| is_zero_o | output | 1 | Word is zero |
| sign_o | output | 1 | Sign of the word |
| scale_o | output | L(N−2)+ES+1 | Signed regime·2^ES + exponent |
| frac_o | output | N−ES−3 | Fraction bits, still in two's complement for negative words |
| grs_o | output | 3 | Guard/round/sticky, always zero |
| mant_o | output | N−ES−1 | Two's-complement mantissa {sign, ~sign, fraction} |

## Verification
The bench decodes |word| the textbook way and derives the expected scale and mantissa for each sign. Negative words with a zero fraction are where a design that negated, or that left out the compensation, would be off by a factor of two. Words whose regime reaches the last bit expose a counter that does not return N−2 on an all-zero fold; such a design would give maxpos and minpos wrong scales. The exhaustive sweeps at ES = 0, 1 and 2 catch an exponent that is left un-inverted for negative words, which would show up as scale errors on every negative value with a non-trivial exponent.

// File: rtl/posit_twos_decoder.sv
module posit_twos_decoder #(
  parameter int N  = 16,
  parameter int ES = 1
) (
  input  logic [N-1:0]                     word_i,
  output logic                             is_nar_o,
  output logic                             is_zero_o,
  output logic                             sign_o,
  output logic [$clog2(N-1)+ES:0]          scale_o,
  output logic [N-ES-4:0]                  frac_o,
  output logic [2:0]                       grs_o,
  output logic [N-ES-2:0]                  mant_o
);
  localparam int RW     = N - 2;
  localparam int LZW    = $clog2(N - 1);
  localparam int FW     = N - ES - 3;
  localparam int XW     = N - 3;
  localparam int SC_MIN = -(N - 1) * (1 << ES);
  localparam int SC_MAX = (N - 1) * (1 << ES) - 1;

  logic [RW-1:0]  fold;
  logic [LZW-1:0] lz, ilz;
  logic           rpos;
  logic [LZW:0]   regime;
  logic [XW-1:0]  ef;
  logic           tail_zero;
  logic [RW-1:0]  run_probe;

  assign fold = word_i[N-2:1] ^ word_i[N-3:0];

  always_comb begin
    lz = LZW'(RW);
    for (int i = 0; i < RW; i++)
      if (fold[i]) lz = LZW'(RW - 1 - i);
  end

  assign ilz    = ~lz;
  assign rpos   = word_i[N-1] ^ word_i[N-2];
  assign regime = rpos ? {1'b0, ~ilz} : {1'b1, ilz};
  assign ef     = word_i[N-4:0] << lz;

  assign tail_zero = ~|word_i[N-2:0];
  assign is_nar_o  = tail_zero & word_i[N-1];
  assign is_zero_o = tail_zero & ~word_i[N-1];
  assign sign_o    = word_i[N-1];
  assign frac_o    = ef[FW-1:0];
  assign grs_o     = 3'b000;
  assign mant_o    = {word_i[N-1], ~word_i[N-1], ef[FW-1:0]};

  generate
    if (ES > 0) begin : g_exp
      logic [ES-1:0] ex;
      assign ex      = ef[XW-1 -: ES] ^ {ES{word_i[N-1]}};
      assign scale_o = {regime, ex};
    end else begin : g_noexp
      assign scale_o = regime;
    end
  endgenerate

  assign run_probe = word_i[N-3:0] << lz;

  always_comb begin
    if (!$isunknown(word_i)) begin
      AST_FLAG_EXCL: assert ($onehot0({is_nar_o, is_zero_o})); // R1
      if (!tail_zero) begin
        AST_SCALE_RANGE: assert (int'($signed(scale_o)) >= SC_MIN && int'($signed(scale_o)) <= SC_MAX); // R7
        if (lz < LZW'(RW)) begin
          AST_RUN_END: assert (run_probe[RW-1] != word_i[N-2]); // R9
        end else begin
          AST_RUN_FULL: assert ((&word_i[N-2:0]) || !(|word_i[N-2:0])); // R9
        end
      end
    end
  end
endmodule

// File: tb/posit_twos_decoder_tb.sv
module posit_twos_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  logic [7:0]  wa, wb, wc;
  logic [15:0] wd;

  logic na, za, sa, nb, zb, sb, nc, zc, sc, nd, zd, sd;
  logic [3:0] sca;  logic [4:0] fa;  logic [2:0] ga; logic [6:0]  ma;
  logic [4:0] scb;  logic [3:0] fb;  logic [2:0] gb; logic [5:0]  mb;
  logic [5:0] scc;  logic [2:0] fc;  logic [2:0] gc; logic [4:0]  mc;
  logic [5:0] scd;  logic [11:0] fd; logic [2:0] gd; logic [13:0] md;

  posit_twos_decoder #(.N(8), .ES(0)) dut_i (
    .word_i(wa), .is_nar_o(na), .is_zero_o(za), .sign_o(sa),
    .scale_o(sca), .frac_o(fa), .grs_o(ga), .mant_o(ma));
  posit_twos_decoder #(.N(8), .ES(1)) dut_i_b (
    .word_i(wb), .is_nar_o(nb), .is_zero_o(zb), .sign_o(sb),
    .scale_o(scb), .frac_o(fb), .grs_o(gb), .mant_o(mb));
  posit_twos_decoder #(.N(8), .ES(2)) dut_i_c (
    .word_i(wc), .is_nar_o(nc), .is_zero_o(zc), .sign_o(sc),
    .scale_o(scc), .frac_o(fc), .grs_o(gc), .mant_o(mc));
  posit_twos_decoder #(.N(16), .ES(1)) dut_i_d (
    .word_i(wd), .is_nar_o(nd), .is_zero_o(zd), .sign_o(sd),
    .scale_o(scd), .frac_o(fd), .grs_o(gd), .mant_o(md));

  task automatic chk(input string req, input int n, input int es, input longint w,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s N=%0d ES=%0d word=0x%0h actual=%0d expected=%0d", req, n, es, w, act, exp);
    end
  endtask

  task automatic verify(input int n, input int es, input longint w, input bit nar,
                        input bit zero, input bit sg, input longint scl,
                        input longint mant, input longint grs);
    longint mask, tail, p, v, t, ex, fr, s, rg, one;
    int msb, r0, k, rem, fw;
    bit inr;
    string stag;
    mask = (longint'(1) << n) - 1;
    w    = w & mask;
    msb  = int'((w >> (n - 1)) & 1);
    tail = w & (mask >> 1);
    if (tail == 0) begin
      chk("R1", n, es, w, longint'(zero), longint'(msb == 0));
      chk("R2", n, es, w, longint'(nar), longint'(msb == 1));
      return;
    end
    chk("R1", n, es, w, longint'(zero), 0);
    chk("R2", n, es, w, longint'(nar), 0);
    chk("R3", n, es, w, longint'(sg), longint'(msb));
    chk("R6", n, es, w, grs, 0);
    fw  = n - es - 3;
    one = longint'(1) << fw;
    inr = msb ? (mant >= -2 * one && mant < -one) : (mant >= one && mant < 2 * one);
    chk("R5", n, es, w, longint'(inr), 1);
    p  = msb ? ((-w) & mask) : w;
    r0 = int'((p >> (n - 2)) & 1);
    k  = 0;
    for (int b = n - 2; b >= 0; b--) begin
      if (int'((p >> b) & 1) == r0) k++;
      else break;
    end
    rg  = r0 ? longint'(k - 1) : -longint'(k);
    rem = n - 2 - k;
    if (rem < 0) rem = 0;
    v  = p & ((longint'(1) << rem) - 1);
    t  = v << (n - 3 - rem);
    ex = t >> fw;
    fr = t & (one - 1);
    s  = rg * (longint'(1) << es) + ex;
    stag = (k >= n - 2) ? "R9" : ((es == 0) ? "R10" : "R7");
    if (!msb) begin
      chk(stag, n, es, w, scl, s);
      chk("R4", n, es, w, mant, one + fr);
    end else if (fr != 0) begin
      chk(stag, n, es, w, scl, s);
      chk("R4", n, es, w, mant, -(one + fr));
    end else begin
      chk("R8", n, es, w, scl, s - 1);
      chk("R8", n, es, w, mant, -2 * one);
    end
  endtask

  task automatic verify_all();
    verify(8, 0, longint'(wa), na, za, sa, longint'($signed(sca)), longint'($signed(ma)), longint'(ga));
    verify(8, 1, longint'(wb), nb, zb, sb, longint'($signed(scb)), longint'($signed(mb)), longint'(gb));
    verify(8, 2, longint'(wc), nc, zc, sc, longint'($signed(scc)), longint'($signed(mc)), longint'(gc));
    verify(16, 1, longint'(wd), nd, zd, sd, longint'($signed(scd)), longint'($signed(md)), longint'(gd));
  endtask

  initial begin
    logic [15:0] directed [8];
    directed[0] = 16'h7FFF; directed[1] = 16'h0001;
    directed[2] = 16'h8001; directed[3] = 16'hFFFF;
    directed[4] = 16'h8000; directed[5] = 16'h0000;
    directed[6] = 16'hC000; directed[7] = 16'h4000;
    wa = '0; wb = '0; wc = '0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    verify_all(); // R1: reset state is an all-zero word
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3256; cyc++) begin
      @(posedge clk);
      #1;
      if (cyc < 256) begin
        wa = 8'(cyc); wb = 8'(cyc); wc = 8'(cyc);
      end else begin
        wa = 8'($urandom); wb = 8'($urandom); wc = 8'($urandom);
      end
      if (cyc < 8) wd = directed[cyc]; // R9: extreme regimes, NaR, zero, +-1
      else wd = 16'($urandom);
      @(negedge clk);
      verify_all();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule